// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Register Bank

This block is the register end of a memory device's serial control port. The device is one of several on a chained serial bus. Register requests reach the block already deserialized. Each request holds a 6-bit device field, a register address, a read/write flag and 16 bits of write data. The block acts on a request only when the device field equals its own programmable identity. It keeps one read/write control register and one read-only capability register. For a read it returns a registered response one cycle after the request.

The control register sets the chain repeat output and exports the power and thermal control bits to the rest of the chip. When its repeater bit is set, the serial input is copied to the next device in the chain. When the bit is clear, the output is held high. Two resets act on the block. The serial-interface reset initializes every defined control field. The command-driven set/clear reset leaves the control register untouched.

Top module: `chain_cfg_regs`

## Requirements
- R1: After the serial-interface reset (`sio_rst_n` low), the control register reads 0x007F. The identity field (bits 5:0) is 0x3F, the repeater bit (bit 6) is 1, and all other bits are 0. The block exports `wake_ok`=1 with every other exported control bit at 0.
- R2: A request whose `req_dev` differs from the identity field gives no response (`rsp_valid` stays 0) and changes no register.
- R3: When the repeater bit (bit 6) is 1, `sio_out` equals `sio_in`. When the bit is 0, `sio_out` is 1.
- R4: The control register is at address 0x021 and can be read and written. A write stores bits 13:0 except bit 12. Bits 15:14 read as 0. The layout is: bits 5:0 identity, 6 repeater, 7 exit select, 8 nap self-refresh, 9 power-down self-refresh, 10 low-power self-refresh, 11 temperature enable, 12 temperature status, 13 disable.
- R5: The capability register is at address 0x023 and reads {protocol version 6'd1 in bits 15:10, refresh-bank bits 3'b101 in bits 9:7, `DOUBLE_BANK` in bit 6, `MFR_ID` in bits 5:0}. Writes to it are ignored.
- R6: A read of any other address returns 0. A write to any other address changes nothing.
- R7: A matching read sets `rsp_valid` to 1 for exactly the cycle after the request, with `rsp_data` valid in that cycle. Writes and idle cycles give `rsp_valid`=0.
- R8: `setclr_rst` does not change the control register.
- R9: The temperature status bit (bit 12) reads as `thermal_trip` AND the temperature enable bit. It cannot be written.
- R10: `exit_sel`, `nap_sr_en`, `pdn_sr_en`, `lp_sr_en` and `temp_en` follow control bits 7, 8, 9, 10 and 11. `wake_ok` is 0 while the disable bit (bit 13) is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sio_rst_n | input | 1 | Serial-interface reset, active low, asynchronous |
| setclr_rst | input | 1 | Command-driven set/clear reset; no effect on the control register |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 6 | Device field of the request |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 16 | Read response data |
| sio_in | input | 1 | Serial input from the previous device |
| sio_out | output | 1 | Serial output to the next device |
| thermal_trip | input | 1 | Thermal trip-point indication |
| exit_sel | output | 1 | Power-exit select bit |
| nap_sr_en | output | 1 | Nap self-refresh enable |
| pdn_sr_en | output | 1 | Power-down self-refresh enable |
| lp_sr_en | output | 1 | Low-power self-refresh enable |
| temp_en | output | 1 | Temperature sensing enable |
| wake_ok | output | 1 | Exits from nap or power-down are permitted |

## Verification
The assertions assume that requests arrive as single-cycle, fully formed words. They also assume that `req_addr` and `req_dev` are stable and known whenever `req_valid` is high. The bench drives each request for one cycle on the falling edge and drops `req_valid` before the next falling edge. It samples the response one cycle later, so it never overlaps requests. It sweeps every non-matching identity, every unmapped address of the 10-bit space and a set of control-word patterns. The identity field is kept in each written word, which keeps the bench able to address the block.

// File: rtl/chain_cfg_regs.sv
module chain_cfg_regs #(
  parameter int ADDR_W = 10,
  parameter bit DOUBLE_BANK = 1'b0,
  parameter logic [5:0] MFR_ID = 6'h05
) (
  input  logic              clk,
  input  logic              sio_rst_n,
  input  logic              setclr_rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [5:0]        req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  input  logic              sio_in,
  output logic              sio_out,
  input  logic              thermal_trip,
  output logic              exit_sel,
  output logic              nap_sr_en,
  output logic              pdn_sr_en,
  output logic              lp_sr_en,
  output logic              temp_en,
  output logic              wake_ok
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(10'h021);
  localparam logic [ADDR_W-1:0] CAP_ADDR  = ADDR_W'(10'h023);
  localparam logic [15:0] CTRL_RST  = 16'h007F;
  localparam logic [15:0] CTRL_MASK = 16'h2FFF;
  localparam logic [15:0] CAP_VAL   = {6'd1, 3'b101, DOUBLE_BANK, MFR_ID};

  logic [15:0] ctrl_q;
  logic [15:0] ctrl_rd;
  logic        hit;
  logic        tsq;

  assign hit = req_valid && (req_dev == ctrl_q[5:0]);
  assign tsq = thermal_trip & ctrl_q[11];
  assign ctrl_rd = ctrl_q | {3'b000, tsq, 12'h000};

  always_ff @(posedge clk or negedge sio_rst_n) begin
    if (!sio_rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (hit && req_write && req_addr == CTRL_ADDR) begin
      ctrl_q <= req_wdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge sio_rst_n) begin
    if (!sio_rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 16'h0000;
    end else begin
      rsp_valid <= hit && !req_write;
      if (hit && !req_write) begin
        if (req_addr == CTRL_ADDR)     rsp_data <= ctrl_rd;
        else if (req_addr == CAP_ADDR) rsp_data <= CAP_VAL;
        else                           rsp_data <= 16'h0000;
      end else begin
        rsp_data <= 16'h0000;
      end
    end
  end

  assign sio_out   = ctrl_q[6] ? sio_in : 1'b1;
  assign exit_sel  = ctrl_q[7];
  assign nap_sr_en = ctrl_q[8];
  assign pdn_sr_en = ctrl_q[9];
  assign lp_sr_en  = ctrl_q[10];
  assign temp_en   = ctrl_q[11];
  assign wake_ok   = ~ctrl_q[13];

  p_mismatch_r2: assert property (@(posedge clk) disable iff (!sio_rst_n)
    (req_valid && req_dev != ctrl_q[5:0]) |=> ($stable(ctrl_q) && !rsp_valid));

  p_hold_high_r3: assert property (@(posedge clk) disable iff (!sio_rst_n)
    !ctrl_q[6] |-> sio_out);

  p_cap_ro_r5: assert property (@(posedge clk) disable iff (!sio_rst_n)
    (req_valid && req_addr == CAP_ADDR) |=> $stable(ctrl_q));

  p_unmapped_r6: assert property (@(posedge clk) disable iff (!sio_rst_n)
    (req_valid && !req_write && req_addr != CTRL_ADDR && req_addr != CAP_ADDR)
      |=> (rsp_data == 16'h0000));

  p_rsp_strobe_r7: assert property (@(posedge clk) disable iff (!sio_rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_setclr_r8: assert property (@(posedge clk) disable iff (!sio_rst_n)
    (setclr_rst && !(req_valid && req_write)) |=> $stable(ctrl_q));

  p_tsq_gate_r9: assert property (@(posedge clk) disable iff (!sio_rst_n)
    (req_valid && !req_write && req_addr == CTRL_ADDR && !temp_en) |=> !rsp_data[12]);

  p_disable_r10: assert property (@(posedge clk) disable iff (!sio_rst_n)
    ctrl_q[13] |-> !wake_ok);

endmodule

// File: tb/chain_cfg_regs_test.sv
`timescale 1ns/1ps
module chain_cfg_regs_test;
  localparam int AW = 10;
  localparam bit DBL = 1'b0;
  localparam logic [5:0] MFR = 6'h05;

  logic clk = 0, sio_rst_n = 0, setclr_rst = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_dev = 0;
  logic [AW-1:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic rsp_valid;
  logic [15:0] rsp_data;
  logic sio_in = 0, sio_out, thermal_trip = 0;
  logic exit_sel, nap_sr_en, pdn_sr_en, lp_sr_en, temp_en, wake_ok;

  int checks = 0, errors = 0;
  logic [15:0] exp_ctrl;
  logic [5:0] id;

  chain_cfg_regs #(.ADDR_W(AW), .DOUBLE_BANK(DBL), .MFR_ID(MFR)) uut (
    .clk(clk), .sio_rst_n(sio_rst_n), .setclr_rst(setclr_rst),
    .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sio_in(sio_in), .sio_out(sio_out),
    .thermal_trip(thermal_trip), .exit_sel(exit_sel), .nap_sr_en(nap_sr_en),
    .pdn_sr_en(pdn_sr_en), .lp_sr_en(lp_sr_en), .temp_en(temp_en),
    .wake_ok(wake_ok));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] dev,
                        input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_check(string req, input logic [5:0] dev,
                          input logic [AW-1:0] a, input logic [15:0] expv);
    access(1'b0, dev, a, 16'h0);
    check(req, {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, expv});
  endtask

  task automatic wr_ctrl(input logic [15:0] d);
    access(1'b1, id, 10'h021, d);
    check("R7 no rsp on write", {31'd0, rsp_valid}, 32'd0);
    exp_ctrl = d & 16'h2FFF;
    id = d[5:0];
  endtask

  task automatic check_exports(string req);
    check(req, {26'd0, exit_sel, nap_sr_en, pdn_sr_en, lp_sr_en, temp_en, wake_ok},
          {26'd0, exp_ctrl[7], exp_ctrl[8], exp_ctrl[9], exp_ctrl[10], exp_ctrl[11], ~exp_ctrl[13]});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] cap;
    cap = (16'd1 << 10) | (16'd5 << 7) | (16'(DBL) << 6) | 16'(MFR);
    #23 sio_rst_n = 1;
    id = 6'h3F; exp_ctrl = 16'h007F;
    @(negedge clk);
    check("R7 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check_exports("R1 exports after reset");
    rd_check("R1 ctrl reset value", 6'h3F, 10'h021, 16'h007F);

    for (int s = 0; s < 2; s++) begin
      sio_in = s[0]; #1;
      check("R3 repeat on", {31'd0, sio_out}, {31'd0, s[0]});
    end

    for (int d = 0; d < 63; d++) begin
      access(1'b1, 6'(d), 10'h021, 16'h0000);
      check("R2 mismatch write no rsp", {31'd0, rsp_valid}, 32'd0);
      access(1'b0, 6'(d), 10'h021, 16'h0000);
      check("R2 mismatch read no rsp", {31'd0, rsp_valid}, 32'd0);
    end
    rd_check("R2 ctrl unchanged", id, 10'h021, exp_ctrl);

    for (int k = 0; k < 40; k++) begin
      logic [15:0] p;
      p = 16'(k * 16'h0A5B + k * k * 16'h0311);
      p[5:0] = 6'(k + 7);
      wr_ctrl(p);
      rd_check("R4 ctrl write/readback", id, 10'h021, exp_ctrl);
      check_exports("R10 exported bits");
      for (int s = 0; s < 2; s++) begin
        sio_in = s[0]; #1;
        check("R3 repeater output", {31'd0, sio_out}, {31'd0, exp_ctrl[6] ? s[0] : 1'b1});
      end
    end

    wr_ctrl({2'b00, 1'b1, 1'b0, 4'h0, 8'h40} | 16'h0015);
    check("R10 disable blocks wake", {31'd0, wake_ok}, 32'd0);
    wr_ctrl(16'h0055);
    check("R10 wake permitted", {31'd0, wake_ok}, 32'd1);

    wr_ctrl(16'h1855);
    thermal_trip = 1;
    rd_check("R9 tsq set when enabled", id, 10'h021, 16'h1855);
    thermal_trip = 0;
    rd_check("R9 tsq clear no trip, not writable", id, 10'h021, 16'h0855);
    wr_ctrl(16'h1055);
    thermal_trip = 1;
    rd_check("R9 tsq masked when disabled", id, 10'h021, 16'h0055);
    thermal_trip = 0;

    rd_check("R5 capability value", id, 10'h023, cap);
    access(1'b1, id, 10'h023, 16'hFFFF);
    rd_check("R5 capability after write", id, 10'h023, cap);
    rd_check("R5 ctrl unaffected", id, 10'h021, exp_ctrl);

    for (int a = 0; a < 1024; a++) begin
      if (a != 'h21 && a != 'h23) begin
        access(1'b1, id, 10'(a), 16'hFFC0 | 16'(id));
        rd_check("R6 unmapped reads zero", id, 10'(a), 16'h0000);
      end
    end
    rd_check("R6 ctrl unchanged by unmapped writes", id, 10'h021, exp_ctrl);

    @(negedge clk); setclr_rst = 1;
    repeat (3) @(negedge clk);
    setclr_rst = 0;
    rd_check("R8 set/clear reset leaves ctrl", id, 10'h021, exp_ctrl);

    @(negedge clk); sio_rst_n = 0;
    @(negedge clk); sio_rst_n = 1;
    id = 6'h3F; exp_ctrl = 16'h007F;
    check_exports("R1 exports after second reset");
    rd_check("R1 ctrl after second reset", 6'h3F, 10'h021, 16'h007F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule